// File: doc/BRIEF.md
# Opmode-Steered Three-Input ALU

This block is the second arithmetic stage of a multiply-accumulate slice. Three operand selectors, named X, Y and Z, are driven by a 7-bit operand-routing field. X chooses among zero, the first multiplier partial product, the registered result and the A:B concatenation. Y chooses among zero, the second partial product, a constant of all ones and the C operand. Z chooses among zero, the cascade input, the registered result, C, and arithmetically right-shifted copies of the cascade input and of the result. The shifted copies right-justify partial products when wider multiplies are chained across slices.

A 4-bit function field selects the operation. X, Y and the carry-in are always summed. Z is then either added to that sum or has the sum subtracted from it. Two bitwise logic functions combine X and Z instead. A function code that is not defined raises a registered mode error. The error is also raised when a logic function is combined with a multiplier operand, and when the Z routing code is unused. In all three cases the result register keeps its previous value.

The 48-bit result register loads only while the clock enable is high. A synchronous clear empties it whatever the enable. An asynchronous active-low reset, released through a two-stage synchronizer, also empties it. Feeding the result back through X or Z gives accumulate operation.

Top module: `opalu`

## Requirements
- R1: After the reset input is deasserted and two clock edges have passed, result is 0 and mode_err is 0.
- R2: Routing bits [1:0] select X as follows. 00 selects zero. 01 selects partial product 1, sign-extended to 48 bits. 10 selects the registered result. 11 selects {a_in, b_in}, with a_in in the upper 30 bits.
- R3: Routing bits [3:2] select Y as follows. 00 selects zero. 01 selects partial product 2, sign-extended. 10 selects all ones. 11 selects c_in.
- R4: Routing bits [6:4] select Z as follows. 000 selects zero. 001 selects cas_in. 010 selects the registered result. 011 selects c_in.
- R5: Z code 100 selects cas_in arithmetically shifted right by 17 bits. Z code 101 selects the registered result shifted the same way.
- R6: Function code 0000 loads Z + X + Y + carry_in, modulo 2^48, on the next enabled edge.
- R7: Function code 0011 loads Z - (X + Y + carry_in), modulo 2^48.
- R8: Function code 1100 loads the bitwise AND of X and Z. Function code 1101 loads the bitwise OR of X and Z.
- R9: Any other function code sets mode_err to 1 on the next enabled edge and leaves result unchanged. A later legal operation loads its result and returns mode_err to 0.
- R10: A logic function code (1100 or 1101) combined with X code 01 or Y code 01 sets mode_err and leaves result unchanged.
- R11: Z codes 110 and 111 set mode_err and leave result unchanged.
- R12: While ce is 0 and sync_clr is 0, result and mode_err hold their values.
- R13: sync_clr high clears result and mode_err on the next edge, even when ce is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for the result and error registers |
| sync_clr | input | 1 | Synchronous clear, takes priority over ce |
| pp1 | input | 43 | Multiplier partial product 1, two's complement |
| pp2 | input | 43 | Multiplier partial product 2, two's complement |
| a_in | input | 30 | A operand, upper part of the A:B concatenation |
| b_in | input | 18 | B operand, lower part of the A:B concatenation |
| c_in | input | 48 | C operand |
| cas_in | input | 48 | Cascade input from the neighbouring slice |
| carry_in | input | 1 | Carry-in added with X and Y |
| opmode | input | 7 | Operand routing: [1:0] X, [3:2] Y, [6:4] Z |
| alumode | input | 4 | Function select |
| result | output | 48 | Registered result |
| mode_err | output | 1 | Registered illegal-mode flag |

## Verification
A table of operand routings is walked so that every X, Y and Z source reaches the result at least once. Each row uses operand values that differ from one another, so a swapped or mis-decoded selector gives a visibly different sum. Some rows carry a carry-in of 1, which separates the carry path from the operands. The shifted Z paths are tried with a positive cascade value and with a negative one, which shows whether the shift is arithmetic or logical. Directed cases then drive each kind of illegal combination, followed by a legal operation, to show that the result is held and that the error flag clears. Further cases check hold under a low enable, and a clear issued with the enable low.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'b0000,
    FN_SUB = 4'b0011,
    FN_AND = 4'b1100,
    FN_OR  = 4'b1101
  } fn_e;

  localparam logic [1:0] XS_ZERO = 2'b00;
  localparam logic [1:0] XS_MUL  = 2'b01;
  localparam logic [1:0] XS_ACC  = 2'b10;
  localparam logic [1:0] XS_AB   = 2'b11;

  localparam logic [1:0] YS_ZERO = 2'b00;
  localparam logic [1:0] YS_MUL  = 2'b01;
  localparam logic [1:0] YS_ONES = 2'b10;
  localparam logic [1:0] YS_C    = 2'b11;

  localparam logic [2:0] ZS_ZERO   = 3'b000;
  localparam logic [2:0] ZS_CAS    = 3'b001;
  localparam logic [2:0] ZS_ACC    = 3'b010;
  localparam logic [2:0] ZS_C      = 3'b011;
  localparam logic [2:0] ZS_CAS_SH = 3'b100;
  localparam logic [2:0] ZS_ACC_SH = 3'b101;
endpackage

// File: rtl/opalu_rst_sync.sv
module opalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/opalu_xy_mux.sv
module opalu_xy_mux
  import opalu_pkg::*;
#(
  parameter int W   = 48,
  parameter int PPW = 43,
  parameter int AW  = 30,
  parameter int BW  = 18
) (
  input  logic [1:0]     xsel,
  input  logic [1:0]     ysel,
  input  logic [PPW-1:0] pp1,
  input  logic [PPW-1:0] pp2,
  input  logic [AW-1:0]  a_in,
  input  logic [BW-1:0]  b_in,
  input  logic [W-1:0]   c_in,
  input  logic [W-1:0]   acc,
  output logic [W-1:0]   x_out,
  output logic [W-1:0]   y_out,
  output logic           mult_used
);
  localparam int ABW = AW + BW;

  logic [W-1:0] pp1_ext, pp2_ext, ab_cat;

  assign pp1_ext = {{(W-PPW){pp1[PPW-1]}}, pp1};
  assign pp2_ext = {{(W-PPW){pp2[PPW-1]}}, pp2};

  generate
    if (ABW >= W) begin : g_ab_trunc
      logic [ABW-1:0] ab_full;
      assign ab_full = {a_in, b_in};
      assign ab_cat  = ab_full[W-1:0];
    end else begin : g_ab_pad
      assign ab_cat = {{(W-ABW){1'b0}}, a_in, b_in};
    end
  endgenerate

  always_comb begin
    unique case (xsel)
      XS_ZERO: x_out = '0;
      XS_MUL:  x_out = pp1_ext;
      XS_ACC:  x_out = acc;
      default: x_out = ab_cat;
    endcase
  end

  always_comb begin
    unique case (ysel)
      YS_ZERO: y_out = '0;
      YS_MUL:  y_out = pp2_ext;
      YS_ONES: y_out = '1;
      default: y_out = c_in;
    endcase
  end

  assign mult_used = (xsel == XS_MUL) || (ysel == YS_MUL);
endmodule

// File: rtl/opalu_z_mux.sv
module opalu_z_mux
  import opalu_pkg::*;
#(
  parameter int W  = 48,
  parameter int SH = 17
) (
  input  logic [2:0]   zsel,
  input  logic [W-1:0] cas_in,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] z_out,
  output logic         z_bad
);
  logic [W-1:0] cas_sh, acc_sh;

  assign cas_sh = {{SH{cas_in[W-1]}}, cas_in[W-1:SH]};
  assign acc_sh = {{SH{acc[W-1]}}, acc[W-1:SH]};

  always_comb begin
    z_bad = 1'b0;
    case (zsel)
      ZS_ZERO:   z_out = '0;
      ZS_CAS:    z_out = cas_in;
      ZS_ACC:    z_out = acc;
      ZS_C:      z_out = c_in;
      ZS_CAS_SH: z_out = cas_sh;
      ZS_ACC_SH: z_out = acc_sh;
      default: begin
        z_out = '0;
        z_bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opalu_core.sv
module opalu_core
  import opalu_pkg::*;
#(
  parameter int W = 48
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         fn_bad,
  output logic         fn_logic
);
  logic [W-1:0] xy_sum;

  assign xy_sum = x + y + {{(W-1){1'b0}}, cin};

  always_comb begin
    fn_bad   = 1'b0;
    fn_logic = 1'b0;
    case (fn)
      FN_ADD: res = z + xy_sum;
      FN_SUB: res = z - xy_sum;
      FN_AND: begin
        res      = x & z;
        fn_logic = 1'b1;
      end
      FN_OR: begin
        res      = x | z;
        fn_logic = 1'b1;
      end
      default: begin
        res    = '0;
        fn_bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opalu.sv
module opalu
  import opalu_pkg::*;
#(
  parameter int W   = 48,
  parameter int PPW = 43,
  parameter int AW  = 30,
  parameter int BW  = 18,
  parameter int SH  = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic           sync_clr,
  input  logic [PPW-1:0] pp1,
  input  logic [PPW-1:0] pp2,
  input  logic [AW-1:0]  a_in,
  input  logic [BW-1:0]  b_in,
  input  logic [W-1:0]   c_in,
  input  logic [W-1:0]   cas_in,
  input  logic           carry_in,
  input  logic [6:0]     opmode,
  input  logic [3:0]     alumode,
  output logic [W-1:0]   result,
  output logic           mode_err
);
  logic         rst_sync_n;
  logic [W-1:0] x_v, y_v, z_v, core_res;
  logic         mult_used, z_bad, fn_bad, fn_logic, err_now;
  logic [W-1:0] result_d;
  logic         err_d;

  opalu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  opalu_xy_mux #(.W(W), .PPW(PPW), .AW(AW), .BW(BW)) u_xy (
    .xsel      (opmode[1:0]),
    .ysel      (opmode[3:2]),
    .pp1       (pp1),
    .pp2       (pp2),
    .a_in      (a_in),
    .b_in      (b_in),
    .c_in      (c_in),
    .acc       (result),
    .x_out     (x_v),
    .y_out     (y_v),
    .mult_used (mult_used)
  );

  opalu_z_mux #(.W(W), .SH(SH)) u_z (
    .zsel   (opmode[6:4]),
    .cas_in (cas_in),
    .acc    (result),
    .c_in   (c_in),
    .z_out  (z_v),
    .z_bad  (z_bad)
  );

  opalu_core #(.W(W)) u_core (
    .fn       (alumode),
    .x        (x_v),
    .y        (y_v),
    .z        (z_v),
    .cin      (carry_in),
    .res      (core_res),
    .fn_bad   (fn_bad),
    .fn_logic (fn_logic)
  );

  assign err_now = fn_bad | z_bad | (fn_logic & mult_used);

  always_comb begin
    result_d = result;
    err_d    = mode_err;
    if (sync_clr) begin
      result_d = '0;
      err_d    = 1'b0;
    end else if (ce) begin
      err_d = err_now;
      if (!err_now) result_d = core_res;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result   <= '0;
      mode_err <= 1'b0;
    end else begin
      result   <= result_d;
      mode_err <= err_d;
    end
  end
endmodule

// File: rtl/opalu_checks.sv
module opalu_checks #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rst_ok_n,
  input logic         ce,
  input logic         sync_clr,
  input logic         carry_in,
  input logic [6:0]   opmode,
  input logic [3:0]   alumode,
  input logic [W-1:0] c_in,
  input logic [W-1:0] result,
  input logic         mode_err
);
  logic fn_known, live;
  assign fn_known = (alumode == 4'b0000) || (alumode == 4'b0011) ||
                    (alumode == 4'b1100) || (alumode == 4'b1101);
  assign live = ce && !sync_clr;

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ce && !sync_clr) |=> ($stable(result) && $stable(mode_err)));

  p_clear_r13: assert property (@(posedge clk) disable iff (!rst_ok_n)
    sync_clr |=> (result == '0 && !mode_err));

  p_bad_fn_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (live && !fn_known) |=> (mode_err && $stable(result)));

  p_logic_mult_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (live && alumode[3:1] == 3'b110 &&
     (opmode[1:0] == 2'b01 || opmode[3:2] == 2'b01)) |=> (mode_err && $stable(result)));

  p_bad_z_r11: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (live && opmode[6:5] == 2'b11) |=> (mode_err && $stable(result)));

  p_add_c_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (live && alumode == 4'b0000 && opmode == 7'b011_00_00 && !carry_in)
      |=> (result == $past(c_in) && !mode_err));

  p_and_zero_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (live && alumode == 4'b1100 && opmode[3:0] == 4'b0000 && !opmode[6])
      |=> (result == '0 && !mode_err));
endmodule

bind opalu opalu_checks #(.W(W)) u_checks (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .ce       (ce),
  .sync_clr (sync_clr),
  .carry_in (carry_in),
  .opmode   (opmode),
  .alumode  (alumode),
  .c_in     (c_in),
  .result   (result),
  .mode_err (mode_err)
);

// File: tb/opalu_test.sv
module opalu_test;
  localparam int W   = 48;
  localparam int PPW = 43;

  typedef struct packed {
    logic [6:0]   op;
    logic [3:0]   fn;
    logic         cin;
    logic [W-1:0] exp;
  } vec_t;

  // opmode written as Z_Y_X
  localparam vec_t VECS [12] = '{
    '{7'b000_00_11, 4'b0000, 1'b0, 48'h0000_0004_0002}, // R2 X=A:B
    '{7'b011_00_10, 4'b0000, 1'b1, 48'h0000_0004_0103}, // R2 X=acc, R4 Z=C, R6 cin
    '{7'b000_01_01, 4'b0000, 1'b0, 48'h0000_0000_0004}, // R2/R3 partial products
    '{7'b011_10_00, 4'b0000, 1'b0, 48'h0000_0000_00FF}, // R3 Y=ones
    '{7'b001_11_00, 4'b0000, 1'b0, 48'h0000_000C_0100}, // R3 Y=C, R4 Z=cas
    '{7'b100_00_00, 4'b0000, 1'b1, 48'h0000_0000_0007}, // R5 cas shifted
    '{7'b011_00_10, 4'b0011, 1'b0, 48'h0000_0000_00F9}, // R7 sub
    '{7'b000_10_00, 4'b0011, 1'b0, 48'h0000_0000_0001}, // R7 sub of ones
    '{7'b001_00_11, 4'b1100, 1'b0, 48'h0000_0004_0000}, // R8 and
    '{7'b011_00_11, 4'b1101, 1'b0, 48'h0000_0004_0102}, // R8 or
    '{7'b010_00_10, 4'b0000, 1'b0, 48'h0000_0008_0204}, // R4 Z=acc
    '{7'b101_00_00, 4'b0000, 1'b0, 48'h0000_0000_0004}  // R5 acc shifted
  };

  logic           clk = 1'b0;
  logic           rst_n, ce, sync_clr, carry_in;
  logic [PPW-1:0] pp1, pp2;
  logic [29:0]    a_in;
  logic [17:0]    b_in;
  logic [W-1:0]   c_in, cas_in, result;
  logic [6:0]     opmode;
  logic [3:0]     alumode;
  logic           mode_err;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  opalu uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sync_clr(sync_clr),
    .pp1(pp1), .pp2(pp2), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .cas_in(cas_in), .carry_in(carry_in), .opmode(opmode),
    .alumode(alumode), .result(result), .mode_err(mode_err)
  );

  task automatic check(input string req, input logic [W-1:0] exp_r, input logic exp_e);
    n_checks++;
    if (result !== exp_r || mode_err !== exp_e) begin
      n_errs++;
      $display("FAIL %s: result=%h err=%b expected result=%h err=%b",
               req, result, mode_err, exp_r, exp_e);
    end
  endtask

  task automatic step(input logic [6:0] op, input logic [3:0] fn, input logic cin,
                      input logic en, input logic clr);
    opmode = op; alumode = fn; carry_in = cin; ce = en; sync_clr = clr;
    @(negedge clk);
    ce = 1'b0; sync_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; ce = 1'b0; sync_clr = 1'b0; carry_in = 1'b0;
    opmode = '0; alumode = '0;
    pp1 = '1; pp2 = 43'd5;
    a_in = 30'd1; b_in = 18'd2;
    c_in = 48'h100; cas_in = 48'h0000_000C_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);

    for (int i = 0; i < 12; i++) begin
      step(VECS[i].op, VECS[i].fn, VECS[i].cin, 1'b1, 1'b0);
      check($sformatf("R2-vector-%0d R6/R7/R8 table", i), VECS[i].exp, 1'b0);
    end

    // R5 negative cascade shifted keeps its sign
    cas_in = 48'hFFFF_FFF0_0000;
    step(7'b100_00_00, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R5 negative shift", 48'hFFFF_FFFF_FFF8, 1'b0);
    step(7'b011_00_00, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R6 load C", 48'h100, 1'b0);

    // R9 unknown function code
    step(7'b011_00_00, 4'b0101, 1'b0, 1'b1, 1'b0);
    check("R9 bad function", 48'h100, 1'b1);
    step(7'b000_00_11, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R9 recovery", 48'h0000_0004_0002, 1'b0);

    // R10 logic with multiplier operand
    step(7'b011_00_01, 4'b1100, 1'b0, 1'b1, 1'b0);
    check("R10 and with X mult", 48'h0000_0004_0002, 1'b1);
    step(7'b011_01_00, 4'b1101, 1'b0, 1'b1, 1'b0);
    check("R10 or with Y mult", 48'h0000_0004_0002, 1'b1);

    // R11 unused Z codes
    step(7'b110_00_11, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R11 Z code 110", 48'h0000_0004_0002, 1'b1);
    step(7'b011_00_00, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R11 recovery", 48'h100, 1'b0);
    step(7'b111_00_00, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R11 Z code 111", 48'h100, 1'b1);

    // R12 hold with enable low
    step(7'b000_00_11, 4'b0000, 1'b0, 1'b0, 1'b0);
    check("R12 hold", 48'h100, 1'b1);
    step(7'b000_00_11, 4'b0000, 1'b0, 1'b1, 1'b0);
    check("R12 enabled load", 48'h0000_0004_0002, 1'b0);

    // R13 clear with enable low
    step(7'b000_00_11, 4'b0000, 1'b0, 1'b0, 1'b1);
    check("R13 clear", '0, 1'b0);

    // R1 asynchronous reset mid-run
    step(7'b011_00_00, 4'b0000, 1'b1, 1'b1, 1'b0);
    check("R6 C plus carry", 48'h101, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset again", '0, 1'b0);

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end
endmodule